// File: doc/BRIEF.md
# Edge-Counting FSK Frequency Discriminator

This block recovers a data bit from a frequency-shift-keyed tone that has already been squared by a limiter. The one-bit input is first passed through a short chain of flip-flops. Each transition of the synchronised signal, rising or falling, fires a retriggerable one-shot of programmable length. Because both edges fire it, the one-shot output carries two pulses per tone period. Its average value therefore rises as the tone frequency rises.

A first-order recursive low-pass filter smooths the pulse train into a level that follows the tone frequency. A registered comparator tests this level against a threshold. The threshold should sit halfway between the settled levels of the two tones. A polarity input decides whether the higher tone or the lower tone gives a 1.

Analog limiting, gain control and band-pass filtering all happen before this block.

Top module: `fsk_pulse_discriminator`

## Requirements
- R1: While reset is asserted, and at the first clock after it, `level` is 0 and `data_out` is 0.
- R2: A rising transition and a falling transition of `lim_in` each start a one-shot pulse. The pulse drives the filter input to full scale, so `level` increases after either kind of edge.
- R3: The one-shot stays high for exactly `pulse_len` clock cycles. A new edge during a pulse reloads the full count. A `pulse_len` of 0 produces no pulse, so `level` stays 0 however `lim_in` toggles.
- R4: `lim_in` passes through a two-stage synchronizer. A change of `lim_in` sampled at clock edge t loads the one-shot at edge t+2, and `level` first changes at edge t+3.
- R5: On each clock, `level` is updated as level + ((x - level) >>> `filt_shift`). Here x is 2^LVL_W-1 while the pulse is high and 0 otherwise. The difference is signed and the shift is arithmetic, so it rounds toward minus infinity.
- R6: With a fixed pulse length, the settled `level` for a higher tone frequency is larger than for a lower one.
- R7: `data_out` is registered. At each clock it takes ((level > thresh) XOR invert), using the `level`, `thresh` and `invert` values from before that clock.
- R8: With `invert` = 0 and `thresh` set to the midpoint of the two settled tone levels, the settled `data_out` is 1 for the higher tone and 0 for the lower tone.
- R9: With `invert` = 1, the tone-to-bit mapping of R8 is reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_in | input | 1 | Squared FSK tone from the limiter |
| pulse_len | input | PW_W | One-shot length in clock cycles |
| filt_shift | input | SH_W | Low-pass filter shift k |
| thresh | input | LVL_W | Decision threshold |
| invert | input | 1 | 1 maps the lower tone to a 1 |
| data_out | output | 1 | Recovered data bit |
| level | output | LVL_W | Filtered frequency level |

## Verification
The assertions assume that `pulse_len`, `filt_shift`, `thresh` and `invert` change only between tones and never in the middle of a pulse. The monotonic checks on the filter assume the shift stays the same from one cycle to the next.

The bench changes every configuration input only on a falling clock edge, while `lim_in` is quiet or the tone is still settling. It drives `lim_in` only at falling edges, with edge spacings long enough that R3 is met by design except in the deliberate retrigger case.

// File: rtl/fskd_pkg.sv
// Package: shared types and defaults for the edge-counting FSK discriminator.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package fskd_pkg;

    // Tone-to-bit mapping selected by the invert input
    typedef enum logic {
        MAP_FAST_IS_ONE = 1'b0,
        MAP_SLOW_IS_ONE = 1'b1
    } tone_map_e;

    // Default widths for pulse count, filter level and shift amount
    localparam int unsigned DEF_PW_W  = 8;
    localparam int unsigned DEF_LVL_W = 16;
    localparam int unsigned DEF_SH_W  = 4;
    localparam int unsigned DEF_SYNC  = 2;

endpackage

// File: rtl/fskd_edge_sync.sv
// Module: synchronizes the limited tone and flags every transition.
// Assumes: din may be asynchronous to clk; NSTAGE >= 2.
// edge_o is high for one cycle after each change has crossed all stages.
module fskd_edge_sync #(
    parameter int unsigned NSTAGE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    localparam int unsigned NFF = NSTAGE + 1;

    logic [NFF-1:0] stage_q;

    // One flop per stage, plus a history flop used for edge detection
    for (genvar g = 0; g < NFF; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture of the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            // Shift the sample one stage further
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    // Transition between the last synchronized sample and the one before
    always_comb edge_o = stage_q[NFF-1] ^ stage_q[NFF-2];

endmodule

// File: rtl/fskd_oneshot.sv
// Module: retriggerable one-shot that turns each edge into a fixed-length pulse.
// Assumes: len is steady while a pulse runs; len = 0 disables the pulse.
module fskd_oneshot #(
    parameter int unsigned PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic [PW_W-1:0] len,
    output logic            pulse
);
    logic [PW_W-1:0] cnt_q;

    // Reload on every trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (trig)        cnt_q <= len;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Pulse is high while the count is nonzero
    always_comb pulse = (cnt_q != '0);

endmodule

// File: rtl/fskd_iir.sv
// Module: first-order recursive low-pass filter, y += (x - y) >>> k.
// Assumes: the input is a one-bit pulse mapped to 0 or full scale.
// Rounding of the arithmetic shift is toward minus infinity.
module fskd_iir #(
    parameter int unsigned LVL_W = 16,
    parameter int unsigned SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic [SH_W-1:0]  shift,
    output logic [LVL_W-1:0] y
);
    localparam int unsigned DW = LVL_W + 1;
    localparam logic [LVL_W-1:0] FULL = {LVL_W{1'b1}};

    logic [LVL_W-1:0]     x;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] step;
    logic [LVL_W-1:0]     y_next;

    // Map the pulse to the filter input and form the shifted error
    always_comb begin
        x      = pulse ? FULL : '0;
        diff   = $signed({1'b0, x}) - $signed({1'b0, y});
        step   = diff >>> shift;
        y_next = y + step[LVL_W-1:0];
    end

    // Hold the filter state
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= y_next;
    end

endmodule

// File: rtl/fskd_slicer.sv
// Module: registered comparator with selectable polarity.
// Assumes: thresh and map change only between decisions.
module fskd_slicer #(
    parameter int unsigned LVL_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LVL_W-1:0]     lvl,
    input  logic [LVL_W-1:0]     thresh,
    input  fskd_pkg::tone_map_e  map,
    output logic                 bit_o
);
    logic above;

    // Raw decision before polarity
    always_comb above = (lvl > thresh);

    // Register the decision with the selected polarity
    always_ff @(posedge clk) begin
        if (!rst_n) bit_o <= 1'b0;
        else        bit_o <= (map == fskd_pkg::MAP_SLOW_IS_ONE) ? ~above : above;
    end

endmodule

// File: rtl/fsk_pulse_discriminator.sv
// Module: top of the edge-counting FSK discriminator.
// Chain: synchronizer/edge detect -> one-shot -> low-pass filter -> slicer.
// Assumes: lim_in is a squared tone; the configuration inputs are quasi-static.
module fsk_pulse_discriminator #(
    parameter int unsigned PW_W  = fskd_pkg::DEF_PW_W,
    parameter int unsigned LVL_W = fskd_pkg::DEF_LVL_W,
    parameter int unsigned SH_W  = fskd_pkg::DEF_SH_W,
    parameter int unsigned NSYNC = fskd_pkg::DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_in,
    input  logic [PW_W-1:0]  pulse_len,
    input  logic [SH_W-1:0]  filt_shift,
    input  logic [LVL_W-1:0] thresh,
    input  logic             invert,
    output logic             data_out,
    output logic [LVL_W-1:0] level
);
    logic                edge_det;
    logic                pulse;
    fskd_pkg::tone_map_e map_sel;

    // Decode the polarity input into the mapping type
    always_comb map_sel = fskd_pkg::tone_map_e'(invert);

    fskd_edge_sync #(.NSTAGE(NSYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (lim_in),
        .edge_o (edge_det)
    );

    fskd_oneshot #(.PW_W(PW_W)) u_shot (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (edge_det),
        .len   (pulse_len),
        .pulse (pulse)
    );

    fskd_iir #(.LVL_W(LVL_W), .SH_W(SH_W)) u_lpf (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (pulse),
        .shift (filt_shift),
        .y     (level)
    );

    fskd_slicer #(.LVL_W(LVL_W)) u_slice (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (level),
        .thresh (thresh),
        .map    (map_sel),
        .bit_o  (data_out)
    );

endmodule

// File: rtl/fskd_checker.sv
// Checker: temporal properties of the discriminator, bound to the top module.
// Assumes: configuration inputs do not change in the middle of a pulse.
module fskd_checker #(
    parameter int unsigned PW_W  = 8,
    parameter int unsigned LVL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_det,
    input logic             pulse,
    input logic [PW_W-1:0]  pulse_len,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] thresh,
    input logic             invert,
    input logic             data_out
);
    AST_EDGE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && pulse_len != '0) |=> pulse); // R2

    AST_NO_SPONTANEOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_det && !pulse) |=> !pulse); // R3

    AST_ZERO_LEN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && pulse_len == '0) |=> !pulse); // R3

    AST_LEVEL_RISES_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> level >= $past(level)); // R5

    AST_LEVEL_FALLS_OFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> level <= $past(level)); // R5

    AST_REGISTERED_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> data_out == (($past(level) > $past(thresh)) ^ $past(invert))); // R7

endmodule

bind fsk_pulse_discriminator fskd_checker #(.PW_W(PW_W), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_det  (edge_det),
    .pulse     (pulse),
    .pulse_len (pulse_len),
    .level     (level),
    .thresh    (thresh),
    .invert    (invert),
    .data_out  (data_out)
);

// File: tb/tb_fsk_pulse_discriminator.sv
module tb_fsk_pulse_discriminator;
    localparam int CLK_PERIOD = 10;
    localparam int PW_W  = 8;
    localparam int LVL_W = 16;
    localparam int SH_W  = 4;
    localparam longint FULL = 65535;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lim_in = 1'b0;
    logic [PW_W-1:0]  pulse_len = 8'd8;
    logic [SH_W-1:0]  filt_shift = 4'd2;
    logic [LVL_W-1:0] thresh = '0;
    logic             invert = 1'b0;
    logic             data_out;
    logic [LVL_W-1:0] level;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    fsk_pulse_discriminator dut (
        .clk(clk), .rst_n(rst_n), .lim_in(lim_in), .pulse_len(pulse_len),
        .filt_shift(filt_shift), .thresh(thresh), .invert(invert),
        .data_out(data_out), .level(level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Scoreboard queues of expected level and bit, one item per clock
    longint exp_lvl_q[$];
    bit     exp_bit_q[$];

    // Reference from the requirements (R4 latency, R3 one-shot, R5 filter, R7 slicer)
    bit     m_s1, m_s2, m_s3, m_d;
    longint m_cnt, m_y;
    always @(posedge clk) begin
        bit     edge_now, pulse_now;
        longint x, diff;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_y = 0; m_d = 0;
        end else begin
            edge_now  = m_s2 ^ m_s3;
            pulse_now = (m_cnt != 0);
            m_d  = (m_y > longint'(thresh)) ^ invert;
            x    = pulse_now ? FULL : 0;
            diff = x - m_y;
            m_y  = m_y + (diff >>> filt_shift);
            if (edge_now)        m_cnt = longint'(pulse_len);
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = lim_in;
        end
        exp_lvl_q.push_back(m_y);
        exp_bit_q.push_back(m_d);
    end

    // Monitor: pop one expected item per clock and compare away from the edge
    always @(negedge clk) begin
        if (exp_lvl_q.size() > 0 && !done) begin
            longint el;
            bit     eb;
            el = exp_lvl_q.pop_front();
            eb = exp_bit_q.pop_front();
            n_run++;
            if (longint'(level) != el) begin
                n_fail++;
                $display("FAIL R5/R4 level actual=%0d expected=%0d at %0t", level, el, $time);
            end
            n_run++;
            if (data_out != eb) begin
                n_fail++;
                $display("FAIL R7 data_out actual=%0d expected=%0d at %0t", data_out, eb, $time);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Drive a tone with the given half period; check data_out over the last 40 cycles
    task automatic run_tone(input int half, input int cycles, input bit chk, input bit expb,
                            input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (i % half == 0) lim_in = ~lim_in;
            if (chk && i >= cycles - 40) check(data_out == expb, tag, data_out, expb);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        longint fast_lvl;
        int     nz;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(level == 0, "R1 level after reset", level, 0);
        check(data_out == 0, "R1 data_out after reset", data_out, 0);

        // R2: rising edge, decay to zero, then falling edge alone raises level
        lim_in = 1'b1;
        idle(60);
        check(level == 0, "R5 decays to zero", level, 0);
        lim_in = 1'b0;
        idle(5);
        check(level > 0, "R2 falling edge raises level", level, 1);

        // R3: zero pulse length gives no pulse
        idle(60);
        pulse_len = 8'd0;
        nz = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (i % 3 == 0) lim_in = ~lim_in;
            if (level != 0) nz++;
        end
        check(nz == 0, "R3 zero length keeps level at 0", nz, 0);

        // R8: fast tone above midpoint, slow tone below
        pulse_len  = 8'd8;
        filt_shift = 4'd7;
        thresh     = 16'd39321;
        run_tone(10, 1500, 1, 1, "R8 fast tone gives 1");
        fast_lvl = longint'(level);
        run_tone(20, 1500, 1, 0, "R8 slow tone gives 0");
        check(longint'(level) < fast_lvl, "R6 slow level below fast level", level, fast_lvl);

        // R9: inverted mapping
        invert = 1'b1;
        run_tone(20, 300, 1, 1, "R9 slow tone gives 1 inverted");
        run_tone(10, 1500, 1, 0, "R9 fast tone gives 0 inverted");

        // R3: retrigger keeps the pulse high continuously
        pulse_len = 8'd12;
        run_tone(10, 2000, 0, 0, "");
        check(level > 16'd65000, "R3 retrigger holds pulse", level, 65000);

        idle(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule